// File: doc/BRIEF.md
# Password-Gated Clock Manager Register Bank

This block is the 32-bit register bank of a clock manager that governs five PLLs and sixteen PLL output channels. A write changes state only if its top byte carries a fixed key. The key bits are stripped before the value is stored, so software never reads them back. One read-only word reports which PLLs are locked. The block builds that word on the fly from each PLL's analog-reset and power-down bits; the word is not stored anywhere.

Each accepted write also raises a one-cycle update strobe toward the logic that recomputes clocks. Which strobes fire depends on the register written. A manager-side PLL register updates the PLL and every channel that hangs off it. An analog-side PLL register updates only the PLL. A channel register updates only that channel. The register window is 0x2000 bytes. Only aligned, full-word accesses take effect.

Top module: `clkmgr_regbank`

## Requirements
- R1: A write takes effect only when bits 31:24 of the write data equal 0x5A. Any other key leaves every register unchanged and raises no strobe.
- R2: An accepted write stores the data with bits 31:24 forced to zero. Every read returns zero in bits 31:24.
- R3: A write needs a byte address with bits 1:0 equal to zero and all four byte strobes set. Otherwise it is ignored. A read at a misaligned address returns zero.
- R4: The lock word is at byte 0x100 and is read-only; writes to it are ignored. PLL i (i = 0..4, in the order A, C, D, H, B) reports in bit 8+i. That bit is 1 when bit 8 (analog reset) of the PLL's manager register is clear and bit 16 (power-down) of its analog control register is clear. All other bits of the lock word are zero.
- R5: The manager register of PLL p is at byte 0x080+4p. A write to it pulses PLL strobe p and the strobe of every channel whose parent is p. Channels 0-3 belong to PLL 0, channels 4-7 to PLL 1, channels 8-11 to PLL 2, channels 12-14 to PLL 3 and channel 15 to PLL 4.
- R6: PLL p has six analog-side registers at byte 0x1000+32p+4k, k = 0..5; k = 0 is the analog control register. A write to any of them pulses PLL strobe p only, with no channel strobe.
- R7: The control register of channel c is at byte 0x1200+4c. A write to it pulses channel strobe c only.
- R8: Strobes are high for exactly the one cycle after the accepted write. Read data and its valid flag appear in the cycle after the read request.
- R9: Reset clears every register and every strobe. Right after reset the lock word reads 0x00001F00.
- R10: Addresses outside the mapped registers read as zero. Writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 13 | Byte address within the window |
| bus_wdata | input | 32 | Write data including key byte |
| bus_strb | input | 4 | Byte strobes; all four must be set |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| pll_upd | output | 5 | One update strobe per PLL |
| chan_upd | output | 16 | One update strobe per channel |

## Verification
Writes to the analog group, the manager registers, the channel registers, the lock word and an unmapped address are each checked by the exact strobe vectors they produce. This separates PLL-only fan-out, PLL-plus-children fan-out, single-channel fan-out and no fan-out at all. Bad keys, partial byte strobes and misaligned addresses are each aimed at a register that already holds a known value. The read-back then shows whether any of them leaked through. The lock word is read after each analog-reset and power-down change, setting and clearing bits on different PLLs, so a wrong bit position or a swapped source bit shows up.

// File: rtl/clkmgr_pkg.sv
package clkmgr_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned ADDR_W     = 13;
    localparam int unsigned NUM_PLL    = 5;
    localparam int unsigned NUM_CH     = 16;
    localparam int unsigned ANA_REGS   = 6;
    localparam int unsigned ANA_STRIDE = 8;

    localparam int unsigned KEY_W      = 8;
    localparam int unsigned KEY_LSB    = 24;
    localparam logic [KEY_W-1:0] KEY_VALUE = 8'h5A;

    localparam int unsigned LOCK_LSB   = 8;
    localparam int unsigned ARST_BIT   = 8;
    localparam int unsigned PDN_BIT    = 16;

    // word indices (byte address / 4)
    localparam int unsigned LOCK_WORD  = 'h040;
    localparam int unsigned MGR_WORD   = 'h020;
    localparam int unsigned ANA_WORD   = 'h400;
    localparam int unsigned CHAN_WORD  = 'h480;

    typedef enum logic [2:0] {
        HIT_NONE,
        HIT_LOCK,
        HIT_MGR,
        HIT_ANA,
        HIT_CHAN
    } hit_e;

    // parent PLL of each output channel
    function automatic int unsigned parent_of(int unsigned ch);
        if (ch < 4)       return 0;
        else if (ch < 8)  return 1;
        else if (ch < 12) return 2;
        else if (ch < 15) return 3;
        else              return 4;
    endfunction

endpackage

// File: rtl/clkmgr_addr_decode.sv
module clkmgr_addr_decode
    import clkmgr_pkg::*;
#(
    parameter int unsigned AW         = ADDR_W,
    parameter int unsigned N_PLL      = NUM_PLL,
    parameter int unsigned N_CH       = NUM_CH,
    parameter int unsigned N_ANA      = ANA_REGS,
    parameter int unsigned ANA_STEP   = ANA_STRIDE,
    parameter int unsigned W_LOCK     = LOCK_WORD,
    parameter int unsigned W_MGR      = MGR_WORD,
    parameter int unsigned W_ANA      = ANA_WORD,
    parameter int unsigned W_CHAN     = CHAN_WORD,
    localparam int unsigned PIDX_W    = $clog2(N_PLL),
    localparam int unsigned CIDX_W    = $clog2(N_CH),
    localparam int unsigned SUB_W     = $clog2(ANA_STEP)
) (
    input  logic [AW-1:0]     addr,
    output hit_e              kind,
    output logic [PIDX_W-1:0] pll_idx,
    output logic [SUB_W-1:0]  sub_idx,
    output logic [CIDX_W-1:0] chan_idx
);

    int unsigned word;
    int unsigned off;

    always_comb begin
        word     = 32'(addr[AW-1:2]);
        off      = 0;
        kind     = HIT_NONE;
        pll_idx  = '0;
        sub_idx  = '0;
        chan_idx = '0;
        if (addr[1:0] == 2'b00) begin
            if (word == W_LOCK) begin
                kind = HIT_LOCK;
            end else if (word >= W_MGR && word < W_MGR + N_PLL) begin
                off     = word - W_MGR;
                kind    = HIT_MGR;
                pll_idx = PIDX_W'(off);
            end else if (word >= W_ANA && word < W_ANA + N_PLL * ANA_STEP) begin
                off = word - W_ANA;
                if ((off % ANA_STEP) < N_ANA) begin
                    kind    = HIT_ANA;
                    pll_idx = PIDX_W'(off / ANA_STEP);
                    sub_idx = SUB_W'(off % ANA_STEP);
                end
            end else if (word >= W_CHAN && word < W_CHAN + N_CH) begin
                off      = word - W_CHAN;
                kind     = HIT_CHAN;
                chan_idx = CIDX_W'(off);
            end
        end
    end

endmodule

// File: rtl/clkmgr_lock_gather.sv
module clkmgr_lock_gather #(
    parameter int unsigned N_PLL   = clkmgr_pkg::NUM_PLL,
    parameter int unsigned DW      = clkmgr_pkg::DATA_W,
    parameter int unsigned LSB     = clkmgr_pkg::LOCK_LSB
) (
    input  logic [N_PLL-1:0] arst_bits,
    input  logic [N_PLL-1:0] pdn_bits,
    output logic [DW-1:0]    lock_word
);

    logic [N_PLL-1:0] locked;

    for (genvar p = 0; p < N_PLL; p++) begin : g_lock
        assign locked[p] = !arst_bits[p] && !pdn_bits[p];
    end

    always_comb begin
        lock_word              = '0;
        lock_word[LSB +: N_PLL] = locked;
    end

endmodule

// File: rtl/clkmgr_strobe_fanout.sv
module clkmgr_strobe_fanout
    import clkmgr_pkg::*;
#(
    parameter int unsigned N_PLL   = NUM_PLL,
    parameter int unsigned N_CH    = NUM_CH,
    localparam int unsigned PIDX_W = $clog2(N_PLL),
    localparam int unsigned CIDX_W = $clog2(N_CH)
) (
    input  logic              wr_ok,
    input  hit_e              kind,
    input  logic [PIDX_W-1:0] pll_idx,
    input  logic [CIDX_W-1:0] chan_idx,
    output logic [N_PLL-1:0]  pll_upd_d,
    output logic [N_CH-1:0]   chan_upd_d
);

    for (genvar p = 0; p < N_PLL; p++) begin : g_pll
        assign pll_upd_d[p] = wr_ok && (kind == HIT_MGR || kind == HIT_ANA)
                              && (pll_idx == PIDX_W'(p));
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        localparam int unsigned PARENT = parent_of(c);
        assign chan_upd_d[c] = wr_ok && (
                   (kind == HIT_CHAN && chan_idx == CIDX_W'(c)) ||
                   (kind == HIT_MGR  && pll_idx  == PIDX_W'(PARENT)));
    end

endmodule

// File: rtl/clkmgr_regbank.sv
module clkmgr_regbank
    import clkmgr_pkg::*;
#(
    parameter int unsigned DW     = DATA_W,
    parameter int unsigned AW     = ADDR_W,
    parameter int unsigned N_PLL  = NUM_PLL,
    parameter int unsigned N_CH   = NUM_CH,
    parameter int unsigned N_ANA  = ANA_REGS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic [DW/8-1:0]  bus_strb,
    output logic [DW-1:0]    bus_rdata,
    output logic             bus_rvalid,
    output logic [N_PLL-1:0] pll_upd,
    output logic [N_CH-1:0]  chan_upd
);

    localparam int unsigned PIDX_W = $clog2(N_PLL);
    localparam int unsigned CIDX_W = $clog2(N_CH);
    localparam int unsigned SUB_W  = $clog2(ANA_STRIDE);
    localparam int unsigned N_AREG = N_PLL * N_ANA;
    localparam int unsigned AIDX_W = $clog2(N_AREG);

    typedef struct packed {
        logic [N_PLL-1:0][DW-1:0]  mgr;
        logic [N_AREG-1:0][DW-1:0] ana;
        logic [N_CH-1:0][DW-1:0]   chan;
        logic [DW-1:0]             rdata;
        logic                      rvalid;
        logic [N_PLL-1:0]          pll_upd;
        logic [N_CH-1:0]           chan_upd;
    } state_t;

    state_t st_d, st_q;

    hit_e              hit_kind;
    logic [PIDX_W-1:0] hit_pll;
    logic [SUB_W-1:0]  hit_sub;
    logic [CIDX_W-1:0] hit_chan;
    logic [AIDX_W-1:0] ana_idx;
    logic              key_ok;
    logic              wr_ok;
    logic [DW-1:0]     clean_data;
    logic [DW-1:0]     lock_word;
    logic [DW-1:0]     rd_value;
    logic [N_PLL-1:0]  arst_bits;
    logic [N_PLL-1:0]  pdn_bits;
    logic [N_PLL-1:0]  pll_upd_d;
    logic [N_CH-1:0]   chan_upd_d;

    clkmgr_addr_decode #(
        .AW     (AW),
        .N_PLL  (N_PLL),
        .N_CH   (N_CH),
        .N_ANA  (N_ANA)
    ) i_decode (
        .addr     (bus_addr),
        .kind     (hit_kind),
        .pll_idx  (hit_pll),
        .sub_idx  (hit_sub),
        .chan_idx (hit_chan)
    );

    for (genvar p = 0; p < N_PLL; p++) begin : g_lock_src
        assign arst_bits[p] = st_q.mgr[p][ARST_BIT];
        assign pdn_bits[p]  = st_q.ana[p*N_ANA][PDN_BIT];
    end

    clkmgr_lock_gather #(
        .N_PLL (N_PLL),
        .DW    (DW)
    ) i_lock (
        .arst_bits (arst_bits),
        .pdn_bits  (pdn_bits),
        .lock_word (lock_word)
    );

    assign key_ok = (bus_wdata[KEY_LSB +: KEY_W] == KEY_VALUE);
    assign wr_ok  = bus_valid && bus_write && key_ok && (&bus_strb);

    clkmgr_strobe_fanout #(
        .N_PLL (N_PLL),
        .N_CH  (N_CH)
    ) i_fanout (
        .wr_ok      (wr_ok),
        .kind       (hit_kind),
        .pll_idx    (hit_pll),
        .chan_idx   (hit_chan),
        .pll_upd_d  (pll_upd_d),
        .chan_upd_d (chan_upd_d)
    );

    always_comb begin
        clean_data                   = bus_wdata;
        clean_data[KEY_LSB +: KEY_W] = '0;
        ana_idx = AIDX_W'(32'(hit_pll) * N_ANA + 32'(hit_sub));
    end

    always_comb begin
        unique case (hit_kind)
            HIT_LOCK: rd_value = lock_word;
            HIT_MGR:  rd_value = st_q.mgr[hit_pll];
            HIT_ANA:  rd_value = st_q.ana[ana_idx];
            HIT_CHAN: rd_value = st_q.chan[hit_chan];
            default:  rd_value = '0;
        endcase
    end

    always_comb begin
        st_d          = st_q;
        st_d.pll_upd  = pll_upd_d;
        st_d.chan_upd = chan_upd_d;
        st_d.rvalid   = bus_valid && !bus_write;
        if (bus_valid && !bus_write) begin
            st_d.rdata = rd_value;
        end
        if (wr_ok) begin
            unique case (hit_kind)
                HIT_MGR:  st_d.mgr[hit_pll]   = clean_data;
                HIT_ANA:  st_d.ana[ana_idx]   = clean_data;
                HIT_CHAN: st_d.chan[hit_chan] = clean_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata  = st_q.rdata;
    assign bus_rvalid = st_q.rvalid;
    assign pll_upd    = st_q.pll_upd;
    assign chan_upd   = st_q.chan_upd;

endmodule

// File: rtl/clkmgr_regbank_chk.sv
module clkmgr_regbank_chk
    import clkmgr_pkg::*;
#(
    parameter int unsigned DW    = DATA_W,
    parameter int unsigned AW    = ADDR_W,
    parameter int unsigned N_PLL = NUM_PLL,
    parameter int unsigned N_CH  = NUM_CH
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic             bus_write,
    input logic [AW-1:0]    bus_addr,
    input logic [DW-1:0]    bus_wdata,
    input logic [DW/8-1:0]  bus_strb,
    input logic [DW-1:0]    bus_rdata,
    input logic             bus_rvalid,
    input logic [N_PLL-1:0] pll_upd,
    input logic [N_CH-1:0]  chan_upd
);

    localparam logic [AW-1:0] LOCK_BYTE = AW'(LOCK_WORD * 4);
    localparam logic [DW-1:0] LOCK_MASK = DW'({N_PLL{1'b1}}) << LOCK_LSB;

    AST_BAD_KEY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_wdata[KEY_LSB +: KEY_W] != KEY_VALUE)
        |=> (pll_upd == '0 && chan_upd == '0)); // R1

    AST_KEY_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> (bus_rdata[KEY_LSB +: KEY_W] == '0)); // R2

    AST_PARTIAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && (bus_strb != '1 || bus_addr[1:0] != 2'b00))
        |=> (pll_upd == '0 && chan_upd == '0)); // R3

    AST_LOCK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == LOCK_BYTE)
        |=> ((bus_rdata & ~LOCK_MASK) == '0)); // R4

    AST_ONE_PLL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pll_upd)); // R6

    AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_upd != '0 || chan_upd != '0)
        |-> $past(bus_valid && bus_write)); // R8

    AST_RVALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_valid && !bus_write)); // R8

endmodule

bind clkmgr_regbank clkmgr_regbank_chk #(
    .DW    (DW),
    .AW    (AW),
    .N_PLL (N_PLL),
    .N_CH  (N_CH)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_strb   (bus_strb),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .pll_upd    (pll_upd),
    .chan_upd   (chan_upd)
);

// File: tb/test_clkmgr_regbank.sv
`timescale 1ns/1ps
module test_clkmgr_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_strb = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [4:0]  pll_upd;
    logic [15:0] chan_upd;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    clkmgr_regbank i_clkmgr_regbank (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_strb   (bus_strb),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .pll_upd    (pll_upd),
        .chan_upd   (chan_upd)
    );

    function automatic logic [12:0] a_mgr(int p);        return 13'(32'h080 + 4*p); endfunction
    function automatic logic [12:0] a_ana(int p, int k); return 13'(32'h1000 + 32*p + 4*k); endfunction
    function automatic logic [12:0] a_chan(int c);       return 13'(32'h1200 + 4*c); endfunction
    localparam logic [12:0] A_LOCK = 13'h100;

    // channel map stated in R5
    function automatic logic [15:0] kids_of(int p);
        logic [15:0] m = '0;
        for (int c = 0; c < 16; c++) begin
            int par;
            par = (c < 4) ? 0 : (c < 8) ? 1 : (c < 12) ? 2 : (c < 15) ? 3 : 4;
            if (par == p) m[c] = 1'b1;
        end
        return m;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    logic [4:0]  got_pll;
    logic [15:0] got_chan;

    task automatic bus_wr(logic [12:0] a, logic [31:0] d, logic [3:0] s);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_strb = s;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        got_pll  = pll_upd;
        got_chan = chan_upd;
    endtask

    task automatic bus_rd(logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_strb = 4'hF;
        @(negedge clk);
        bus_valid = 1'b0;
        chk("R8 rvalid", 32'(bus_rvalid), 32'd1);
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R9 pll strobes after reset", 32'(pll_upd), 32'd0);
        chk("R9 chan strobes after reset", 32'(chan_upd), 32'd0);
        bus_rd(A_LOCK, d);   chk("R9 lock word after reset", d, 32'h1F00);
        bus_rd(a_mgr(0), d); chk("R9 mgr0 cleared", d, 32'h0);
        bus_rd(a_chan(5), d); chk("R9 chan5 cleared", d, 32'h0);
    endtask

    task automatic t_accept();
        logic [31:0] d;
        bus_wr(a_ana(2, 3), 32'h5A12_3456, 4'hF);
        chk("R6 analog write pll strobe", 32'(got_pll), 32'h04);
        chk("R6 analog write no chan strobe", 32'(got_chan), 32'h0);
        @(negedge clk);
        chk("R8 strobe drops after one cycle", 32'({pll_upd, chan_upd}), 32'h0);
        bus_rd(a_ana(2, 3), d); chk("R2 key stripped on store", d, 32'h0012_3456);
    endtask

    task automatic t_bad_key();
        logic [31:0] d;
        bus_wr(a_ana(2, 3), 32'hA5FF_FFFF, 4'hF);
        chk("R1 bad key no strobe", 32'({got_pll, got_chan}), 32'h0);
        bus_wr(a_ana(2, 3), 32'h5B00_0001, 4'hF);
        chk("R1 near key no strobe", 32'({got_pll, got_chan}), 32'h0);
        bus_rd(a_ana(2, 3), d); chk("R1 register unchanged", d, 32'h0012_3456);
    endtask

    task automatic t_access();
        logic [31:0] d;
        bus_wr(a_ana(2, 3), 32'h5A00_0BAD, 4'h7);
        chk("R3 partial strobe no update", 32'({got_pll, got_chan}), 32'h0);
        bus_wr(a_ana(2, 3) + 13'd2, 32'h5A00_0BAD, 4'hF);
        chk("R3 misaligned no update", 32'({got_pll, got_chan}), 32'h0);
        bus_rd(a_ana(2, 3), d); chk("R3 register unchanged", d, 32'h0012_3456);
        bus_rd(a_ana(2, 3) + 13'd1, d); chk("R3 misaligned read zero", d, 32'h0);
    endtask

    task automatic t_mgr();
        logic [31:0] d;
        bus_wr(a_mgr(1), 32'h5A00_0100, 4'hF);
        chk("R5 mgr1 pll strobe", 32'(got_pll), 32'h02);
        chk("R5 mgr1 child strobes", 32'(got_chan), 32'(kids_of(1)));
        bus_rd(A_LOCK, d); chk("R4 analog reset drops lock C", d, 32'h1D00);
        bus_wr(a_mgr(4), 32'h5A00_0000, 4'hF);
        chk("R5 mgr4 pll strobe", 32'(got_pll), 32'h10);
        chk("R5 mgr4 child strobes", 32'(got_chan), 32'(kids_of(4)));
    endtask

    task automatic t_pdn();
        logic [31:0] d;
        bus_wr(a_ana(3, 0), 32'h5A01_0000, 4'hF);
        chk("R6 analog ctrl pll strobe", 32'(got_pll), 32'h08);
        bus_rd(A_LOCK, d); chk("R4 power-down drops lock H", d, 32'h1500);
        bus_wr(a_mgr(1), 32'h5A00_0000, 4'hF);
        bus_rd(A_LOCK, d); chk("R4 lock C returns", d, 32'h1700);
    endtask

    task automatic t_chan();
        logic [31:0] d;
        bus_wr(a_chan(9), 32'h5A00_00AB, 4'hF);
        chk("R7 single channel strobe", 32'(got_chan), 32'h0200);
        chk("R7 no pll strobe", 32'(got_pll), 32'h0);
        bus_rd(a_chan(9), d); chk("R7 channel readback", d, 32'h0000_00AB);
    endtask

    task automatic t_lock_ro();
        logic [31:0] d;
        bus_wr(A_LOCK, 32'h5A00_0000, 4'hF);
        chk("R4 lock write no strobe", 32'({got_pll, got_chan}), 32'h0);
        bus_rd(A_LOCK, d); chk("R4 lock write ignored", d, 32'h1700);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bus_wr(13'h0400, 32'h5AFF_FFFF, 4'hF);
        chk("R10 unmapped write no strobe", 32'({got_pll, got_chan}), 32'h0);
        bus_rd(13'h0400, d); chk("R10 unmapped reads zero", d, 32'h0);
        bus_rd(a_ana(0, 6), d); chk("R10 analog gap reads zero", d, 32'h0);
    endtask

    task automatic t_reset_mid();
        logic [31:0] d;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        bus_rd(a_ana(3, 0), d); chk("R9 analog ctrl cleared", d, 32'h0);
        bus_rd(a_chan(9), d);   chk("R9 channel cleared", d, 32'h0);
        bus_rd(A_LOCK, d);      chk("R9 lock word restored", d, 32'h1F00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_accept();
        t_bad_key();
        t_access();
        t_mgr();
        t_pdn();
        t_chan();
        t_lock_ro();
        t_unmapped();
        t_reset_mid();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule